// File: doc/BRIEF.md
# Error Interrupt Status and Enable Registers

This block collects four error events from a control register module and drives one level-sensitive interrupt line. Each event has one bit in three vectors: a raw status that records every occurrence, an enabled status that records only occurrences seen while enabled, and an enable mask. Software reaches these through a small word-addressed write port with a combinational read-back.

The enable mask has separate write-one-to-set and write-one-to-clear addresses, so software never needs a read-modify-write. One write-one-to-clear address clears both status vectors at once. For debugging, software can force raw bits high, and those bits raise the interrupt like real events. The interrupt output is registered and follows the raw status masked by the enable.

Top module: `err_irq_regs`

## Requirements
- R1: After reset every raw, enabled status and enable bit is 0, irq_o is 0, and every address reads 0.
- R2: Event bits are 0 = proxy violation, 1 = lock violation, 2 = addressing violation, 3 = protection violation. A high event bit sets its raw bit at the next clock edge, whatever its enable.
- R3: An event sets its enabled status bit only if its enable bit is 1 in that cycle. Setting the enable later does not set it. Address 1 reads the enabled status.
- R4: A write to address 2 sets each enable bit whose data bit is 1. Data bits of 0 leave enable bits as they were. Addresses 2 and 3 both read the enable mask.
- R5: A write to address 3 clears each enable bit whose data bit is 1. Data bits of 0 leave enable bits as they were.
- R6: A write to address 1 clears each raw and enabled status bit whose data bit is 1, whether or not that event is enabled.
- R7: A write to address 0 sets each raw bit whose data bit is 1 and leaves the enabled status unchanged. Address 0 reads the raw status.
- R8: irq_o is a register loaded at each edge with the OR over all bits of raw AND enable. It rises or falls one edge after that term changes.
- R9: If an event and a status clear of the same bit share a cycle, the event wins and the raw bit stays set. The enabled status bit also stays set if the event is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Error event pulses, one per source |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Word address for write and read |
| wdata_i | input | NUM_EVT | Write data |
| rdata_o | output | NUM_EVT | Read data for addr_i (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
Status and enable changes appear on rdata_o right after the clock edge that samples the event or write. irq_o follows one edge later, because it is loaded from the raw and enable registers. The scoreboard applies each stimulus across exactly one edge and then predicts the state. It samples one time unit after the following falling edge, so a rising interrupt is first expected after one extra idle cycle. The checks that fall inside that one-cycle lag expect the old irq_o level.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;
  localparam int unsigned NUM_EVT = 4;
  localparam int unsigned ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_RAW    = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 2'd1;
  localparam logic [ADDR_W-1:0] A_EN_SET = 2'd2;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 2'd3;

  typedef struct packed {
    logic inj;
    logic clr;
    logic set;
    logic dis;
  } wr_strb_t;
endpackage

// File: rtl/err_irq_decode.sv
module err_irq_decode
  import err_irq_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_strb_t          strb_o
);
  always_comb begin
    strb_o = '0;
    if (wr_en_i) begin
      unique case (addr_i)
        A_RAW:    strb_o.inj = 1'b1;
        A_STAT:   strb_o.clr = 1'b1;
        A_EN_SET: strb_o.set = 1'b1;
        A_EN_CLR: strb_o.dis = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/err_irq_bit.sv
module err_irq_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic en_i,
  input  logic inj_i,
  input  logic clr_i,
  output logic raw_o,
  output logic ena_o
);
  logic raw_q, ena_q;

  // event has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      ena_q <= 1'b0;
    end else begin
      raw_q <= evt_i | inj_i | (raw_q & ~clr_i);
      ena_q <= (evt_i & en_i) | (ena_q & ~clr_i);
    end
  end

  assign raw_o = raw_q;
  assign ena_o = ena_q;
endmodule

// File: rtl/err_irq_mask.sv
module err_irq_mask #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] dis_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_i) & ~dis_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/err_irq_regs.sv
module err_irq_regs
  import err_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT = err_irq_pkg::NUM_EVT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  output logic [NUM_EVT-1:0] rdata_o,
  output logic               irq_o
);
  wr_strb_t           strb;
  logic [NUM_EVT-1:0] inj_v, clr_v, set_v, dis_v;
  logic [NUM_EVT-1:0] raw_v, ena_v, en_v;
  logic               irq_q;

  err_irq_decode u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .strb_o  (strb)
  );

  assign inj_v = strb.inj ? wdata_i : '0;
  assign clr_v = strb.clr ? wdata_i : '0;
  assign set_v = strb.set ? wdata_i : '0;
  assign dis_v = strb.dis ? wdata_i : '0;

  err_irq_mask #(.N(NUM_EVT)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .dis_i  (dis_v),
    .en_o   (en_v)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    err_irq_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i[i]),
      .en_i   (en_v[i]),
      .inj_i  (inj_v[i]),
      .clr_i  (clr_v[i]),
      .raw_o  (raw_v[i]),
      .ena_o  (ena_v[i])
    );
  end

  always_comb begin
    unique case (addr_i)
      A_RAW:    rdata_o = raw_v;
      A_STAT:   rdata_o = ena_v;
      A_EN_SET,
      A_EN_CLR: rdata_o = en_v;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(raw_v & en_v);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/err_irq_chk.sv
module err_irq_chk
  import err_irq_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      evt_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N-1:0]      wdata_i,
  input logic [N-1:0]      raw_q,
  input logic [N-1:0]      ena_q,
  input logic [N-1:0]      en_q,
  input logic              irq_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (irq_o == 1'b0 && raw_q == '0 && ena_q == '0 && en_q == '0);
    end
  end

  a_r2_evt_sets_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  a_r3_ena_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ena_q & ~$past(ena_q) & ~($past(evt_i) & $past(en_q))) == '0));

  a_r4_en_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_EN_SET) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

  a_r5_en_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_EN_CLR) |=> ((en_q & $past(wdata_i)) == '0));

  a_r6_stat_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_STAT) |=> (((raw_q | ena_q) & $past(wdata_i) & ~$past(evt_i)) == '0));

  a_r8_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == |($past(raw_q) & $past(en_q))));

  a_r9_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_STAT && |(evt_i & wdata_i))
    |=> ((raw_q & $past(evt_i & wdata_i)) == $past(evt_i & wdata_i)));
endmodule

bind err_irq_regs err_irq_chk #(.N(NUM_EVT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .evt_i   (evt_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .raw_q   (raw_v),
  .ena_q   (ena_v),
  .en_q    (en_v),
  .irq_o   (irq_o)
);

// File: tb/sim_err_irq_regs.sv
module sim_err_irq_regs;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [3:0] evt_i;
  logic       wr_en_i;
  logic [1:0] addr_i;
  logic [3:0] wdata_i;
  logic [3:0] rdata_o;
  logic       irq_o;

  always #5 clk = ~clk;

  err_irq_regs u0 (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  typedef struct {
    string      req;
    logic [1:0] addr;
    logic [3:0] exp_rd;
    logic       exp_irq;
  } item_t;

  item_t q[$];
  event  ev_chk;
  int    n_chk = 0;
  int    n_fail = 0;

  // reference state, per requirements
  logic [3:0] m_raw = '0, m_ena = '0, m_en = '0;
  logic       m_irq = 1'b0;

  // monitor: pops expected items and compares with the ports
  initial begin
    item_t it;
    forever begin
      @(ev_chk);
      while (q.size() > 0) begin
        it = q.pop_front();
        n_chk++;
        if (rdata_o !== it.exp_rd) begin
          n_fail++;
          $display("FAIL %s rdata addr=%0d actual=%h expected=%h", it.req, it.addr, rdata_o, it.exp_rd);
        end
        n_chk++;
        if (irq_o !== it.exp_irq) begin
          n_fail++;
          $display("FAIL %s irq actual=%b expected=%b", it.req, irq_o, it.exp_irq);
        end
      end
    end
  end

  // one clock of stimulus, called at a falling edge, returns at the next one
  task automatic step(input logic [3:0] ev, input logic we, input logic [1:0] a,
                      input logic [3:0] wd);
    logic [3:0] clr, inj, st, ds;
    logic       irq_n;
    evt_i = ev; wr_en_i = we; addr_i = a; wdata_i = wd;
    @(posedge clk);
    clr = (we && a == 2'd1) ? wd : 4'h0;
    inj = (we && a == 2'd0) ? wd : 4'h0;
    st  = (we && a == 2'd2) ? wd : 4'h0;
    ds  = (we && a == 2'd3) ? wd : 4'h0;
    irq_n = |(m_raw & m_en);
    m_ena = (m_ena & ~clr) | (ev & m_en);
    m_raw = (m_raw & ~clr) | ev | inj;
    m_en  = (m_en | st) & ~ds;
    m_irq = irq_n;
    @(negedge clk);
    evt_i = '0; wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic idle();
    step(4'h0, 1'b0, 2'd0, 4'h0);
  endtask

  task automatic chk(input logic [1:0] a, input string req);
    item_t it;
    addr_i = a;
    #1;
    it.req = req;
    it.addr = a;
    it.exp_irq = m_irq;
    case (a)
      2'd0:    it.exp_rd = m_raw;
      2'd1:    it.exp_rd = m_ena;
      default: it.exp_rd = m_en;
    endcase
    q.push_back(it);
    -> ev_chk;
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; evt_i = '0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int a = 0; a < 4; a++) chk(2'(a), "R1");

    // R2, R3: disabled proxy event sets raw only
    step(4'b0001, 1'b0, 2'd0, 4'h0);
    chk(2'd0, "R2"); chk(2'd1, "R3");
    idle(); chk(2'd0, "R8");

    // R4: enable bit0, irq one edge later, enabled status stays 0
    step(4'h0, 1'b1, 2'd2, 4'b0001);
    chk(2'd2, "R4"); chk(2'd1, "R3");
    idle(); chk(2'd3, "R8");

    // R4: writing zeros leaves the mask
    step(4'h0, 1'b1, 2'd2, 4'b0000);
    chk(2'd2, "R4");

    // R3: enabled lock event sets both views
    step(4'h0, 1'b1, 2'd2, 4'b0010);
    step(4'b0010, 1'b0, 2'd0, 4'h0);
    chk(2'd1, "R3"); chk(2'd0, "R2");

    // R6: clear bits 0 and 1, irq falls one edge later
    step(4'h0, 1'b1, 2'd1, 4'b0011);
    chk(2'd0, "R6"); chk(2'd1, "R6");
    idle(); chk(2'd0, "R8");

    // R6: clear of a disabled event
    step(4'b0100, 1'b0, 2'd0, 4'h0);
    chk(2'd0, "R2");
    step(4'h0, 1'b1, 2'd1, 4'b0100);
    chk(2'd0, "R6");

    // R5: disable bit0, zero write has no effect
    step(4'h0, 1'b1, 2'd3, 4'b0001);
    chk(2'd3, "R5");
    step(4'h0, 1'b1, 2'd3, 4'b0000);
    chk(2'd2, "R5");

    // R7: injected raw bit raises irq when enabled
    step(4'h0, 1'b1, 2'd2, 4'b1000);
    step(4'h0, 1'b1, 2'd0, 4'b1000);
    chk(2'd0, "R7"); chk(2'd1, "R7");
    idle(); chk(2'd0, "R8");
    step(4'h0, 1'b1, 2'd1, 4'b1000);
    idle(); chk(2'd0, "R8");

    // R9: event and clear of bit3 in the same cycle
    step(4'b1000, 1'b1, 2'd1, 4'b1000);
    chk(2'd0, "R9"); chk(2'd1, "R9");
    idle(); chk(2'd1, "R8");

    finish_run();
  end
endmodule